// File: doc/BRIEF.md
# Microprogram Sequencer with Overlapped Fetch

This block is the control half of a microprogrammed processor. It keeps a micro-address counter, reads 16-bit words from a 64-word control store that is fixed when the chip is built, and holds the word being executed in a microinstruction register. Words marked operational drive a 15-bit micro-operation code onto the control outputs and let the counter step to the next address. Words marked control carry a jump target and a condition selector. The selector is tested against status flags that come back from the datapath.

A routine begins when `start` is pulsed in the idle state. The routine's first address is formed from a 3-bit operation code, which selects one of eight eight-word slots. The word at the next address is fetched while the current word executes. An unconditional jump is taken at fetch time and costs no cycle. A conditional jump holds back the next fetch until its condition is known, which inserts one empty cycle with all control outputs at zero. A dedicated end word raises `done` for one cycle and returns the block to idle.

Top module: `microSequencer`

## Requirements
- R1: While reset is active and in the first cycle after it, `busy`, `done` and `stall` are 0 and `ctrlOut` is all zeros.
- R2: When `start` is 1 at a clock edge while idle, `busy` becomes 1 and `ctrlOut` stays zero in the following cycle. After the next edge the register holds the word at address `opcode`×8, and `microAddr` shows that address.
- R3: A word with bit 15 = 1 is operational. While it is in the register, `ctrlOut` equals its bits 14:0, except for the end word. In the next cycle the register holds the word at the following address, with no stall.
- R4: A word with bit 15 = 0 is a control word: bits 14:12 select the condition and bits 5:0 hold the target. While it is in the register, `ctrlOut` is zero.
- R5: Selector 0 means always. The jump is taken while the word is fetched, so the target word follows it directly with no empty cycle.
- R6: Selectors 1–4 test flags[0]–flags[3]. Selectors 5 and 6 test the inverse of flags[0] and flags[1]. Selector 7 is never true. The flags are sampled in the cycle in which the control word sits in the register.
- R7: Any control word with a nonzero selector is followed by exactly one cycle with `stall` = 1 and `ctrlOut` = 0. The register then holds the target word if the condition was true, and the word at the next address if it was false.
- R8: The word 0xFFFF is the end word. While it is in the register, `done` is 1 for one cycle and `ctrlOut` is 0. In the next cycle `busy` is 0.
- R9: `start` is ignored while `busy` is 1, including the cycle in which `done` is 1.
- R10: The built-in program, with op(x) meaning 0x8000|x and every unlisted address holding the end word:
  - Slot 0: op 0x011, op 0x022.
  - Slot 1: op 0x101, then flags[0]→12, op 0x102, end at 11, op 0x103 at 12.
  - Slot 2 (address 16): always→48.
  - Slot 3: never→30, then flags[3]→30, op 0x301, end, op 0x302 at 30.
  - Slot 4: op 0x7FFE, then !flags[1]→35, end at 34, op 0x404 at 35.
  - Slot 6: op 0x201, then !flags[0]→52, op 0x202, end at 51, op 0x203 at 52.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a routine when idle |
| opcode | input | 3 | Operation code that selects the entry slot |
| flags | input | 4 | Datapath status flags |
| ctrlOut | output | 15 | Micro-operation code driven to the datapath |
| microAddr | output | 6 | Address of the word in the register |
| stall | output | 1 | Empty cycle after a conditional jump |
| busy | output | 1 | A routine is running |
| done | output | 1 | End word is executing |

## Verification
Two functions can fall in the same cycle: the end word that closes a routine and a new `start` request. The bench raises `start` in the very cycle `done` is high and then checks that `busy` is 0 on the next cycle, so the request was dropped. Flag timing is handled the same way. The bench changes the flags exactly in the cycle the branch word is in the register, and again one cycle later during the empty cycle. It then judges which end address the routine reached.

// File: rtl/useqPkg.sv
package useqPkg;
  typedef enum logic {S_IDLE = 1'b0, S_RUN = 1'b1} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEntry;
    logic fetch;
    logic resolve;
    logic clear;
  } seqStrobe_t;

  // decoded view of the microinstruction register
  typedef struct packed {
    logic valid;
    logic isOp;
    logic isEnd;
    logic isCond;
    logic condTrue;
  } seqStatus_t;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import useqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  seqStatus_t status,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       stall
);
  seqState_t state;
  logic stallQ;

  always_comb begin
    strobe = '0;
    done = 1'b0;
    if (state == S_IDLE) begin
      strobe.loadEntry = start;
    end else if (status.valid && status.isEnd) begin
      done = 1'b1;
      strobe.clear = 1'b1;
    end else if (status.valid && status.isCond) begin
      strobe.resolve = 1'b1;
    end else begin
      strobe.fetch = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      stallQ <= 1'b0;
    end else begin
      stallQ <= strobe.resolve;
      if (state == S_IDLE && start) state <= S_RUN;
      else if (done) state <= S_IDLE;
    end
  end

  assign busy = (state == S_RUN);
  assign stall = stallQ;
endmodule

// File: rtl/seqPath.sv
module seqPath
  import useqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int OPC_W = 3,
  parameter int FLAG_W = 4,
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_W-1:0] flags,
  input  seqStrobe_t        strobe,
  output seqStatus_t        status,
  output logic [WORD_W-2:0] ctrlOut,
  output logic [ADDR_W-1:0] microAddr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOT_W = ADDR_W - OPC_W;
  localparam int UOP_W = WORD_W - 1;
  localparam int PAD_W = WORD_W - 1 - SEL_W - ADDR_W;

  function automatic logic [WORD_W-1:0] opW(input int code);
    return {1'b1, UOP_W'(code)};
  endfunction

  function automatic logic [WORD_W-1:0] brW(input int sel, input int tgt);
    return {1'b0, SEL_W'(sel), {PAD_W{1'b0}}, ADDR_W'(tgt)};
  endfunction

  function automatic logic [WORD_W-1:0] romWord(input int a);
    case (a)
      0:  romWord = opW(32'h011);
      1:  romWord = opW(32'h022);
      8:  romWord = opW(32'h101);
      9:  romWord = brW(1, 12);
      10: romWord = opW(32'h102);
      12: romWord = opW(32'h103);
      16: romWord = brW(0, 48);
      24: romWord = brW(7, 30);
      25: romWord = brW(4, 30);
      26: romWord = opW(32'h301);
      30: romWord = opW(32'h302);
      32: romWord = opW(32'h7FFE);
      33: romWord = brW(6, 35);
      35: romWord = opW(32'h404);
      48: romWord = opW(32'h201);
      49: romWord = brW(5, 52);
      50: romWord = opW(32'h202);
      52: romWord = opW(32'h203);
      default: romWord = '1;
    endcase
  endfunction

  logic [WORD_W-1:0] store [DEPTH];
  for (genvar i = 0; i < DEPTH; i++) begin : g_store
    assign store[i] = romWord(i);
  end

  logic [ADDR_W-1:0] upc, mirAddr, entryAddr, fTgt, mTgt;
  logic [WORD_W-1:0] mir, fetched;
  logic mirValid, fJump;
  logic [SEL_W-1:0] mSel, fSel;
  logic unusedRsvd;

  assign fetched = store[upc];
  assign fSel = fetched[WORD_W-2 -: SEL_W];
  assign fTgt = fetched[ADDR_W-1:0];
  assign fJump = !fetched[WORD_W-1] && (fSel == '0);
  assign entryAddr = {opcode, {SLOT_W{1'b0}}};

  assign mSel = mir[WORD_W-2 -: SEL_W];
  assign mTgt = mir[ADDR_W-1:0];
  assign unusedRsvd = ^mir[WORD_W-2-SEL_W:ADDR_W];

  always_comb begin
    status.condTrue = 1'b0;
    if (mSel == '0) status.condTrue = 1'b1;
    for (int k = 0; k < FLAG_W; k++)
      if (int'(mSel) == k + 1) status.condTrue = flags[k];
    if (int'(mSel) == FLAG_W + 1) status.condTrue = !flags[0];
    if (int'(mSel) == FLAG_W + 2) status.condTrue = !flags[1];
  end

  assign status.valid = mirValid;
  assign status.isOp = mir[WORD_W-1];
  assign status.isEnd = mir[WORD_W-1] && (&mir[UOP_W-1:0]);
  assign status.isCond = !mir[WORD_W-1] && (mSel != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upc <= '0;
      mir <= '0;
      mirAddr <= '0;
      mirValid <= 1'b0;
    end else if (strobe.loadEntry) begin
      upc <= entryAddr;
      mirValid <= 1'b0;
    end else if (strobe.fetch) begin
      mir <= fetched;
      mirAddr <= upc;
      mirValid <= 1'b1;
      upc <= fJump ? fTgt : upc + 1'b1;
    end else if (strobe.resolve) begin
      mirValid <= 1'b0;
      if (status.condTrue) upc <= mTgt;
    end else if (strobe.clear) begin
      mirValid <= 1'b0;
    end
  end

  assign ctrlOut = (mirValid && status.isOp && !status.isEnd) ? mir[UOP_W-1:0] : '0;
  assign microAddr = mirAddr;
endmodule

// File: rtl/microSequencer.sv
module microSequencer
  import useqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int OPC_W = 3,
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FLAG_W-1:0] flags,
  output logic [WORD_W-2:0] ctrlOut,
  output logic [ADDR_W-1:0] microAddr,
  output logic              stall,
  output logic              busy,
  output logic              done
);
  seqStrobe_t strobe;
  seqStatus_t status;

  seqCtrl ctrl (
    .clk(clk), .rstN(rstN), .start(start), .status(status),
    .strobe(strobe), .busy(busy), .done(done), .stall(stall)
  );

  seqPath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OPC_W(OPC_W), .FLAG_W(FLAG_W)) path (
    .clk(clk), .rstN(rstN), .opcode(opcode), .flags(flags), .strobe(strobe),
    .status(status), .ctrlOut(ctrlOut), .microAddr(microAddr)
  );
endmodule

// File: rtl/microSequencerChecker.sv
module microSequencerChecker #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [WORD_W-2:0] ctrlOut,
  input logic [ADDR_W-1:0] microAddr,
  input logic              stall,
  input logic              busy,
  input logic              done
);
  a_r7_bubble_quiet: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> (ctrlOut == '0));

  a_r7_stall_single: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlOut != '0) |=> (microAddr == ADDR_W'($past(microAddr) + 1'b1)));

  always_comb begin
    if (rstN && !busy) a_r1_idle_quiet: assert (ctrlOut == '0 && !stall);
  end
endmodule

bind microSequencer microSequencerChecker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chk (
  .clk(clk), .rstN(rstN), .start(start), .ctrlOut(ctrlOut), .microAddr(microAddr),
  .stall(stall), .busy(busy), .done(done)
);

// File: tb/microSequencer_test.sv
`timescale 1ns/1ps
module microSequencer_test;
  logic clk = 0, rstN = 0, start = 0;
  logic [2:0] opcode = '0;
  logic [3:0] flags = '0;
  logic [14:0] ctrlOut;
  logic [5:0] microAddr;
  logic stall, busy, done;
  int checks = 0, errors = 0;
  int nCyc, sumCtrl, nStall, endAddr;

  always #2.5 clk = ~clk;

  microSequencer uut (.clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .flags(flags),
    .ctrlOut(ctrlOut), .microAddr(microAddr), .stall(stall), .busy(busy), .done(done));

  typedef struct packed {
    logic [2:0] opc; logic [3:0] fl; logic [7:0] n;
    logic [31:0] sum; logic [7:0] st; logic [5:0] endA;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{3'd0, 4'h0, 8'd3, 32'h033,  8'd0, 6'd2},
    '{3'd1, 4'h1, 8'd5, 32'h204,  8'd1, 6'd13},
    '{3'd1, 4'h0, 8'd5, 32'h203,  8'd1, 6'd11},
    '{3'd2, 4'h0, 8'd6, 32'h404,  8'd1, 6'd53},
    '{3'd2, 4'h1, 8'd6, 32'h403,  8'd1, 6'd51},
    '{3'd3, 4'h0, 8'd6, 32'h301,  8'd2, 6'd27},
    '{3'd3, 4'h8, 8'd6, 32'h302,  8'd2, 6'd31},
    '{3'd3, 4'hF, 8'd6, 32'h302,  8'd2, 6'd31},
    '{3'd4, 4'h0, 8'd5, 32'h8402, 8'd1, 6'd36},
    '{3'd4, 4'h2, 8'd4, 32'h7FFE, 8'd1, 6'd34},
    '{3'd5, 4'h0, 8'd1, 32'h0,    8'd0, 6'd40},
    '{3'd6, 4'h0, 8'd5, 32'h404,  8'd1, 6'd53}
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // flags change after sample flipAt; start pulse after sample startAt
  task automatic runRoutine(input logic [2:0] opc, input logic [3:0] fl,
                            input int flipAt, input logic [3:0] flNew,
                            input int startAt, input logic [2:0] opcSpur);
    int k;
    logic [5:0] prevAddr;
    logic [14:0] prevCtrl;
    nCyc = 0; sumCtrl = 0; nStall = 0; endAddr = -1;
    @(negedge clk);
    opcode = opc; flags = fl; start = 1;
    @(negedge clk);
    start = 0;
    check(busy && ctrlOut == 0, "R2", "busy/ctrl after start", {busy, ctrlOut}, 32'h8000);
    k = 0; prevCtrl = '0; prevAddr = '0;
    while (k < 40) begin
      @(negedge clk);
      k++;
      if (k == 1) check(microAddr == 6'(opc * 8), "R2", "entry address", microAddr, opc * 8);
      if (k > 1 && prevCtrl != 0)
        check(microAddr == prevAddr + 6'd1, "R3", "address step", microAddr, prevAddr + 6'd1);
      if (stall) begin
        nStall++;
        check(ctrlOut == 0, "R7", "bubble ctrlOut", ctrlOut, 0);
      end
      sumCtrl += int'(ctrlOut);
      prevCtrl = ctrlOut; prevAddr = microAddr;
      start = (k == startAt);
      if (k == startAt) opcode = opcSpur;
      if (k == flipAt) flags = flNew;
      if (done) begin
        check(ctrlOut == 0, "R8", "ctrlOut in end cycle", ctrlOut, 0);
        endAddr = microAddr;
        break;
      end
    end
    nCyc = k;
    @(negedge clk);
    start = 0;
    check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not end, actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !stall && ctrlOut == 0, "R1", "state in reset", {busy, done, stall}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !done && !stall && ctrlOut == 0, "R1", "state after reset", {busy, done, stall}, 0);

    // vector table: R3 R4 R5 R6 R7 R10
    foreach (VECS[i]) begin
      runRoutine(VECS[i].opc, VECS[i].fl, 0, 4'h0, 0, 3'd0);
      check(nCyc == int'(VECS[i].n), "R5/R7", $sformatf("cycles vec %0d", i), nCyc, VECS[i].n);
      check(sumCtrl == int'(VECS[i].sum), "R3 R4", $sformatf("ctrl sum vec %0d", i), sumCtrl, VECS[i].sum);
      check(nStall == int'(VECS[i].st), "R7", $sformatf("stalls vec %0d", i), nStall, VECS[i].st);
      check(endAddr == int'(VECS[i].endA), "R6 R10", $sformatf("end addr vec %0d", i), endAddr, VECS[i].endA);
    end

    // R6: flag raised while branch word (sample 2) is in the register -> taken
    runRoutine(3'd1, 4'h0, 2, 4'h1, 0, 3'd0);
    check(endAddr == 13, "R6", "flag set in branch cycle", endAddr, 13);
    // R6: flag raised during the bubble is too late -> not taken
    runRoutine(3'd1, 4'h0, 3, 4'h1, 0, 3'd0);
    check(endAddr == 11, "R6", "flag set in bubble", endAddr, 11);

    // R9: start during a running routine is ignored
    runRoutine(3'd1, 4'h1, 0, 4'h0, 1, 3'd0);
    check(endAddr == 13 && nCyc == 5, "R9", "start while busy", endAddr, 13);
    // R9: start in the done cycle is ignored (runRoutine checks idle afterwards)
    runRoutine(3'd0, 4'h0, 0, 4'h0, 3, 3'd4);
    check(endAddr == 2, "R9", "start in done cycle", endAddr, 2);
    @(negedge clk);
    check(!busy, "R9", "still idle", busy, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule